// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block takes one packed binary floating-point operand, either 32-bit single or 64-bit double format, and expands it into the form that downstream arithmetic works on. The expanded form has five parts. A signed class code separates zero, finite numbers, infinity and the two kinds of NaN. The sign is passed through. The exponent is unbiased and signed. The mantissa carries an explicit integer bit, three spare bits above it and two low-order guard and round bits below the fraction. A sticky flag is also provided and always starts cleared.

Subnormal inputs are fully normalized during unpacking. A single-cycle leading-zero count shifts the leading one up to the 1.0 position and lowers the exponent to match, so every finite result the block emits has a mantissa in [1.0, 2.0). A single-format fraction is left-aligned into the same mantissa bits that a double uses, which means the logic after this block does not need to know the format.

Operands enter through a valid/ready handshake. Each result is held in an output register with its own valid/ready handshake. A result appears one cycle after its operand is accepted, and the block accepts one operand per cycle while the consumer keeps up.

Top module: `fpu_unpack`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An operand is accepted on a clock edge where `in_valid && in_ready`. Its result is presented with `out_valid` high from the next cycle on. While `out_valid && !out_ready`, every output holds its value. Results leave in the order their operands were accepted.
- R3: `out_class` is a 3-bit two's-complement code:
  - 3'b110 (-2) for a signalling NaN
  - 3'b111 (-1) for a quiet NaN
  - 3'b000 for zero
  - 3'b001 for a finite nonzero number
  - 3'b010 for infinity
- R4: With `in_dbl`=1 the operand is `in_bits[63:0]`: sign at bit 63, exponent field at bits 62:52, fraction at bits 51:0. With `in_dbl`=0 the operand is `in_bits[31:0]`: sign at bit 31, exponent field at bits 30:23, fraction at bits 22:0. In single format, `in_bits[63:32]` has no effect on any output.
- R5: For a normal number (exponent field neither all zeros nor all ones), `out_exp` is the field minus 1023 (double) or minus 127 (single). `out_mant` is `{3'b000, 1'b1, F, 2'b00}`, where F is the 52-bit fraction. A single fraction occupies the top 23 bits of F, and the remaining bits of F are zero.
- R6: For a subnormal (exponent field zero, fraction nonzero), let k be the number of left shifts that bring the leading fraction one to the 1.0 position (mantissa bit 54). Then `out_exp` is -1022-k (double) or -126-k (single), `out_mant` has bit 54 set, and zeros fill the vacated low bits. The smallest double subnormal gives -1074 and the smallest single gives -149.
- R7: For an all-ones exponent field with a nonzero fraction, the class is quiet NaN when the top fraction bit is 1 and signalling NaN otherwise. `out_mant` is `{4'b0000, F, 2'b00}`, so mantissa bit 53 (weight 0.5) is the quiet bit, and `out_exp` is 0.
- R8: Zero (exponent field and fraction both zero) and infinity (exponent field all ones, fraction zero) give `out_mant` = 0 and `out_exp` = 0, with the sign kept.
- R9: The guard and round bits `out_mant[1:0]` and `out_sticky` are 0 on every result.
- R10: `out_sign` equals the operand's sign bit for every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_dbl | input | 1 | 1 = double format, 0 = single format |
| in_bits | input | 64 | Packed operand (single uses the low 32 bits) |
| out_valid | output | 1 | Expanded result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_class | output | 3 | Signed class code |
| out_sign | output | 1 | Sign bit |
| out_exp | output | 13 | Unbiased signed exponent |
| out_mant | output | 58 | Spare(3), integer bit, 52-bit fraction, guard, round |
| out_sticky | output | 1 | Sticky flag, cleared on every result |

## Verification
Each accepted operand's result is due exactly one clock edge after acceptance. It then stays due until a cycle where `out_ready` is high. The bench's reference model therefore pushes the expected result when it sees the accepting condition, and pops and compares it on the first later cycle where the outputs show `out_valid && out_ready`. Every cycle the bench also checks that `in_ready` matches the handshake rule. It checks that a stalled result is unchanged one cycle later, with random backpressure making stalls frequent. All outputs are sampled on the falling clock edge, half a period away from the edge that updates them.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

  // Signed class code: negative values are the NaN kinds.
  typedef enum logic [2:0] {
    CLS_ZERO = 3'b000,
    CLS_NUM  = 3'b001,
    CLS_INF  = 3'b010,
    CLS_SNAN = 3'b110,
    CLS_QNAN = 3'b111
  } fp_class_e;

endpackage

// File: rtl/fpu_unpack_field.sv
// Splits the packed operand into sign, exponent field and a left-aligned
// fraction, for either format (R4).
module fpu_unpack_field #(
  parameter int FRAC_W  = 52,
  parameter int EXP_FW  = 11,
  parameter int SFRAC_W = 23,
  parameter int SEXP_FW = 8,
  parameter int EXP_W   = 13,
  localparam int IN_W   = 1 + EXP_FW + FRAC_W,
  localparam int SIN_W  = 1 + SEXP_FW + SFRAC_W
) (
  input  logic                    dbl,
  input  logic [IN_W-1:0]         bits,
  output logic                    sign,
  output logic [FRAC_W-1:0]       frac,
  output logic [EXP_FW-1:0]       exp_field,
  output logic                    exp_max,
  output logic                    exp_zero,
  output logic signed [EXP_W-1:0] bias
);
  localparam int DBIAS = (1 << (EXP_FW - 1)) - 1;
  localparam int SBIAS = (1 << (SEXP_FW - 1)) - 1;
  localparam int PAD_W = FRAC_W - SFRAC_W;

  logic [SEXP_FW-1:0] s_exp;
  assign s_exp = bits[SIN_W-2 -: SEXP_FW];

  always_comb begin
    if (dbl) begin
      sign      = bits[IN_W-1];
      exp_field = bits[IN_W-2 -: EXP_FW];
      frac      = bits[FRAC_W-1:0];
      exp_max   = &bits[IN_W-2 -: EXP_FW];
      exp_zero  = ~|bits[IN_W-2 -: EXP_FW];
      bias      = EXP_W'(DBIAS);
    end else begin
      // Upper half of bits is never looked at in single format (R4).
      sign      = bits[SIN_W-1];
      exp_field = EXP_FW'(s_exp);
      frac      = {bits[SFRAC_W-1:0], {PAD_W{1'b0}}};
      exp_max   = &s_exp;
      exp_zero  = ~|s_exp;
      bias      = EXP_W'(SBIAS);
    end
  end
endmodule

// File: rtl/fpu_unpack_lzc.sv
// Leading-zero count of a nonzero vector, in one level of logic (R6).
module fpu_unpack_lzc #(
  parameter int W = 52,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpu_unpack_norm.sv
// Classifies the operand and builds the exponent and mantissa (R3, R5-R8).
module fpu_unpack_norm
  import fpu_unpack_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXP_FW = 11,
  parameter int NG     = 2,
  parameter int SPARE  = 3,
  parameter int EXP_W  = 13,
  localparam int MANT_W = SPARE + 1 + FRAC_W + NG,
  localparam int LZW    = $clog2(FRAC_W)
) (
  input  logic [FRAC_W-1:0]       frac,
  input  logic [EXP_FW-1:0]       exp_field,
  input  logic                    exp_max,
  input  logic                    exp_zero,
  input  logic signed [EXP_W-1:0] bias,
  output fp_class_e               cls,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [MANT_W-1:0]       mant
);
  logic [LZW-1:0]    lz;
  logic [LZW:0]      shamt;
  logic [FRAC_W-1:0] den_frac;
  logic              frac_nz;

  fpu_unpack_lzc #(.W(FRAC_W)) u_lzc (.vec(frac), .cnt(lz));

  assign frac_nz  = |frac;
  // One extra shift drops the leading one into the integer bit.
  assign shamt    = {1'b0, lz} + 1'b1;
  assign den_frac = frac << shamt;

  always_comb begin
    cls   = CLS_ZERO;
    exp_o = '0;
    mant  = '0;
    if (exp_max) begin
      if (frac_nz) begin
        cls  = frac[FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
        mant = {{(SPARE + 1){1'b0}}, frac, {NG{1'b0}}};
      end else begin
        cls = CLS_INF;
      end
    end else if (exp_zero) begin
      if (frac_nz) begin
        cls   = CLS_NUM;
        exp_o = EXP_W'(1) - bias - EXP_W'(shamt);
        mant  = {{SPARE{1'b0}}, 1'b1, den_frac, {NG{1'b0}}};
      end
    end else begin
      cls   = CLS_NUM;
      exp_o = EXP_W'(exp_field) - bias;
      mant  = {{SPARE{1'b0}}, 1'b1, frac, {NG{1'b0}}};
    end
  end
endmodule

// File: rtl/fpu_unpack.sv
module fpu_unpack
  import fpu_unpack_pkg::*;
#(
  parameter int FRAC_W  = 52,
  parameter int EXP_FW  = 11,
  parameter int SFRAC_W = 23,
  parameter int SEXP_FW = 8,
  parameter int NG      = 2,
  parameter int SPARE   = 3,
  parameter int EXP_W   = 13,
  localparam int IN_W    = 1 + EXP_FW + FRAC_W,
  localparam int MANT_W  = SPARE + 1 + FRAC_W + NG,
  localparam int ONE_POS = NG + FRAC_W,
  localparam int QBIT    = ONE_POS - 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_dbl,
  input  logic [IN_W-1:0]         in_bits,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [2:0]              out_class,
  output logic                    out_sign,
  output logic signed [EXP_W-1:0] out_exp,
  output logic [MANT_W-1:0]       out_mant,
  output logic                    out_sticky
);
  logic                    f_sign, f_max, f_zero;
  logic [FRAC_W-1:0]       f_frac;
  logic [EXP_FW-1:0]       f_exp;
  logic signed [EXP_W-1:0] f_bias;
  fp_class_e               n_cls;
  logic signed [EXP_W-1:0] n_exp;
  logic [MANT_W-1:0]       n_mant;
  logic                    accept;

  fpu_unpack_field #(
    .FRAC_W(FRAC_W), .EXP_FW(EXP_FW), .SFRAC_W(SFRAC_W),
    .SEXP_FW(SEXP_FW), .EXP_W(EXP_W)
  ) u_field (
    .dbl(in_dbl), .bits(in_bits), .sign(f_sign), .frac(f_frac),
    .exp_field(f_exp), .exp_max(f_max), .exp_zero(f_zero), .bias(f_bias)
  );

  fpu_unpack_norm #(
    .FRAC_W(FRAC_W), .EXP_FW(EXP_FW), .NG(NG), .SPARE(SPARE), .EXP_W(EXP_W)
  ) u_norm (
    .frac(f_frac), .exp_field(f_exp), .exp_max(f_max), .exp_zero(f_zero),
    .bias(f_bias), .cls(n_cls), .exp_o(n_exp), .mant(n_mant)
  );

  // Output register acts as a one-entry pipeline stage (R2).
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_class  <= CLS_ZERO;
      out_sign   <= 1'b0;
      out_exp    <= '0;
      out_mant   <= '0;
      out_sticky <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_class  <= n_cls;
      out_sign   <= f_sign;
      out_exp    <= n_exp;
      out_mant   <= n_mant;
      out_sticky <= 1'b0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_mant)
      && $stable(out_exp) && $stable(out_class) && $stable(out_sign));

  assert_num_lead_one_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_class == CLS_NUM |->
      out_mant[ONE_POS] && out_mant[MANT_W-1:ONE_POS+1] == '0);

  assert_nan_quiet_bit_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_class[2] |->
      (out_mant[QBIT] == (out_class == CLS_QNAN)) && !out_mant[ONE_POS]);

  assert_special_empty_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_class == CLS_ZERO || out_class == CLS_INF) |->
      out_mant == '0 && out_exp == '0);

  assert_guard_round_clear_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_mant[NG-1:0] == '0);
endmodule

// File: tb/tb_fpu_unpack.sv
module tb_fpu_unpack;
  typedef struct packed {
    logic [2:0]         c;
    logic               s;
    logic signed [12:0] e;
    logic [57:0]        m;
  } rec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_dbl = 1'b0, out_ready = 1'b1;
  logic [63:0] in_bits = '0;
  logic in_ready, out_valid, out_sign, out_sticky;
  logic [2:0] out_class;
  logic signed [12:0] out_exp;
  logic [57:0] out_mant;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit bp_en = 1'b0, done = 1'b0, run = 1'b0;
  rec_t  exp_q[$];
  string tag_q[$];
  rec_t  held;
  bit    held_v = 1'b0;

  always #5 clk = ~clk;

  fpu_unpack dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dbl(in_dbl), .in_bits(in_bits), .out_valid(out_valid),
    .out_ready(out_ready), .out_class(out_class), .out_sign(out_sign),
    .out_exp(out_exp), .out_mant(out_mant), .out_sticky(out_sticky)
  );

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic rec_t model(bit dbl, logic [63:0] b);
    rec_t r;
    logic [51:0] f;
    int ef, bias, emax, k;
    if (dbl) begin
      r.s = b[63]; ef = int'(b[62:52]); f = b[51:0]; bias = 1023; emax = 2047;
    end else begin
      r.s = b[31]; ef = int'(b[30:23]); f = {b[22:0], 29'd0}; bias = 127; emax = 255;
    end
    r.c = 3'b000; r.e = '0; r.m = '0;
    if (ef == emax) begin
      if (f == 0) r.c = 3'b010;
      else begin
        r.c = f[51] ? 3'b111 : 3'b110;
        r.m = {4'b0000, f, 2'b00};
      end
    end else if (ef == 0) begin
      if (f != 0) begin
        k = 0;
        while (!f[51]) begin f = f << 1; k++; end
        r.c = 3'b001;
        r.e = 13'(1 - bias - (k + 1));
        r.m = {3'b000, 1'b1, f[50:0], 1'b0, 2'b00};
      end
    end else begin
      r.c = 3'b001;
      r.e = 13'(ef - bias);
      r.m = {3'b000, 1'b1, f, 2'b00};
    end
    return r;
  endfunction

  // Backpressure changes just after each rising edge.
  always @(posedge clk) begin
    #1;
    out_ready = bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  // Monitor: all sampling on the falling edge.
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "R2", "watchdog expired", 64'(cycles), 64'd0);
      finish_run();
    end
    if (rst) begin
      chk(!out_valid && in_ready, "R1", "idle during reset",
          {in_ready, out_valid}, 64'b10);
    end else if (run) begin
      chk(in_ready == (!out_valid || out_ready), "R2", "in_ready rule",
          64'(in_ready), 64'(!out_valid || out_ready));
      if (held_v) begin
        chk(out_valid && out_class == held.c && out_sign == held.s &&
            out_exp == held.e && out_mant == held.m, "R2", "hold on stall",
            64'(out_mant), 64'(held.m));
      end
      held_v = out_valid && !out_ready;
      held   = '{out_class, out_sign, out_exp, out_mant};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected result", 64'(out_mant), 64'd0);
        end else begin
          rec_t r;
          string t;
          r = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_class == r.c, "R3", "class", 64'(out_class), 64'(r.c));
          chk(out_sign == r.s, "R10", "sign", 64'(out_sign), 64'(r.s));
          chk(out_exp == r.e, t, "exponent", 64'(out_exp), 64'(r.e));
          chk(out_mant == r.m, t, "mantissa", 64'(out_mant), 64'(r.m));
          chk(out_mant[1:0] == 2'b00 && !out_sticky, "R9", "guard/round/sticky",
              {out_sticky, out_mant[1:0]}, 64'd0);
        end
      end
    end
  end

  task automatic send(bit dbl, logic [63:0] b, string tag);
    rec_t r;
    bit ok;
    string t;
    r = model(dbl, b);
    if (tag != "") t = tag;
    else if (r.c[2]) t = "R7";
    else if (r.c != 3'b001) t = "R8";
    else if (r.e < (dbl ? -1022 : -126)) t = "R6";
    else t = "R5";
    @(posedge clk); #1;
    in_valid = 1'b1; in_dbl = dbl; in_bits = b;
    do begin
      @(negedge clk);
      ok = in_ready;
    end while (!ok);
    exp_q.push_back(r);
    tag_q.push_back(t);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", "idle after reset", {in_ready, out_valid}, 64'b10);
    run = 1'b1;
    // Doubles
    send(1, 64'h3FF0000000000000, "R5");
    send(1, 64'hC004000000000000, "R5");
    send(1, 64'h7FEFFFFFFFFFFFFF, "R5");
    send(1, 64'h0010000000000000, "R5");
    send(1, 64'h0000000000000001, "R6");
    send(1, 64'h0008000000000000, "R6");
    send(1, 64'h800FFFFFFFFFFFFF, "R6");
    send(1, 64'h0000000000000000, "R8");
    send(1, 64'h8000000000000000, "R8");
    send(1, 64'h7FF0000000000000, "R8");
    send(1, 64'hFFF0000000000000, "R8");
    send(1, 64'h7FF8000000000000, "R7");
    send(1, 64'h7FF0000000000001, "R7");
    send(1, 64'hFFF8000000000001, "R7");
    // Singles, upper half deliberately noisy
    send(0, 64'h000000003F800000, "R5");
    send(0, 64'hDEADBEEF3F800000, "R4");
    send(0, 64'hFFFFFFFFC0490FDB, "R4");
    send(0, 64'h000000007F7FFFFF, "R5");
    send(0, 64'h0000000000800000, "R5");
    send(0, 64'h0000000000000001, "R6");
    send(0, 64'hA5A5A5A500400000, "R6");
    send(0, 64'h0000000080000000, "R8");
    send(0, 64'h123456787F800000, "R4");
    send(0, 64'h00000000FF800000, "R8");
    send(0, 64'h000000007FC00000, "R7");
    send(0, 64'hFFFFFFFF7F800001, "R4");
    // Random sweep under backpressure
    bp_en = 1'b1;
    for (int i = 0; i < 800; i++) begin
      bit dbl;
      logic [63:0] b;
      int sel;
      dbl = 1'($urandom_range(0, 1));
      b   = {$urandom, $urandom};
      sel = $urandom_range(0, 3);
      if (dbl) begin
        if (sel == 0) b[62:52] = '0;
        if (sel == 1) b[62:52] = '1;
        if (sel == 2) begin b[62:52] = '0; b[51:0] = b[51:0] >> $urandom_range(0, 51); end
      end else begin
        if (sel == 0) b[30:23] = '0;
        if (sel == 1) b[30:23] = '1;
        if (sel == 2) begin b[30:23] = '0; b[22:0] = b[22:0] >> $urandom_range(0, 22); end
      end
      send(dbl, b, "");
    end
    @(posedge clk); #1 in_valid = 1'b0;
    for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "all results delivered", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule